// File: doc/BRIEF.md
# Exception Pending and Active State Sequencer

This block keeps the pending, active and enabled state of every exception vector of an interrupt controller. Vector numbers 1 to 15 are internal system exceptions, and vectors from 16 upward belong to external interrupt lines. The block turns events into state changes. The events are level changes on the external lines, set, clear and enable requests from the register decoder, a tick pulse from the system timer, an acknowledge from the core and a handler completion from the core. The state table goes out as three bit vectors to a separate priority resolver. That resolver picks a winner that is enabled, pending and above the execution priority, and offers it back on the acknowledge port.

A synchronous fault is a vector from hard fault up to, but not including, the deferred service call. If such a fault is pended while it cannot be taken, the block promotes it to hard fault and raises a sticky forced flag. If even hard fault cannot be taken, the block raises a sticky lockup output. The block handles one event per clock. The order is completion, then acknowledge, then register request, then timer tick, then external edges. A tick or an edge that loses arbitration waits for a later free cycle.

Top module: `exc_state_sequencer`

## Requirements
- R1: After reset every pending and active bit is 0, the current exception number is 0, and forced, lockup, bad-completion and return-to-base are 0. The enabled bits are set for vectors 2, 3, 11, 12, 14 and 15 only. With 8 lines that is 24'h00D80C.
- R2: A rising level on external line i sets the pending bit of vector 16+i. A falling level leaves that pending bit set.
- R3: On a legal completion of vector v≥16, the pending bit of v is set again if line v-16 is high at that moment. It is left unchanged if the line is low.
- R4: Completing a vector whose active bit is 0, or a vector number out of range, sets cmp_bad_o for exactly the next cycle. No state changes.
- R5: A legal completion clears the vector's active bit. ret_base_o then holds 1 if at most one vector is still active, and 0 if more than one is.
- R6: An acknowledge of a vector that is both pending and enabled clears its pending bit, sets its active bit and makes it the current exception number. An acknowledge of any other vector is ignored.
- R7: A set-pending request (op 0) on a vector from 3 to 13 escalates in two cases. The first is when its priority (fixed at -1 for vector 3) is greater than or equal to the execution priority. The second is when the vector is disabled. On escalation vector 3 is pended instead of the requested vector, and forced_o is set and stays set. Otherwise the requested vector is pended.
- R8: If escalation is needed while the execution priority is -1 or lower, lockup_o is set and stays set, and no pending bit changes.
- R9: A tick pulse pends vector 15 without any escalation check. A pulse that loses arbitration is held until it is served.
- R10: Request op codes are 0 set pending, 1 clear pending, 2 enable and 3 disable. A request to vector 0 or to a number at or above the vector count changes nothing.
- R11: One event is served per cycle, in this order: completion, qualified acknowledge, request, tick, external edges. An acknowledge that arrives together with a completion is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_lvl_i | input | NUM_EXT | External interrupt line levels |
| req_valid_i | input | 1 | Register request strobe |
| req_op_i | input | 2 | Request op: 0 set pend, 1 clear pend, 2 enable, 3 disable |
| req_vec_i | input | VW | Vector number of the request |
| req_prio_i | input | PRIO_BITS+2 | Signed priority of the requested vector |
| tick_i | input | 1 | Timer tick pulse |
| exec_prio_i | input | PRIO_BITS+2 | Signed current execution priority |
| ack_i | input | 1 | Core acknowledges the offered winner |
| ack_vec_i | input | VW | Vector being acknowledged |
| done_i | input | 1 | Core completes a handler |
| done_vec_i | input | VW | Vector being completed |
| pend_o | output | NUM_VEC | Pending bit per vector |
| act_o | output | NUM_VEC | Active bit per vector |
| ena_o | output | NUM_VEC | Enabled bit per vector |
| cur_exc_o | output | VW | Last acknowledged exception number |
| forced_o | output | 1 | Sticky escalation flag |
| lockup_o | output | 1 | Sticky lockup flag |
| cmp_bad_o | output | 1 | One-cycle illegal completion flag |
| ret_base_o | output | 1 | Return-to-base value of the last legal completion |

## Verification
A wrong pending or active bit shows up on pend_o or act_o at the next clock edge, because every event writes those registers directly and the outputs are the registers. A mistake in arbitration or escalation also appears within one cycle, as a vector pended in the wrong place or at the wrong time, or as forced_o or lockup_o rising too early or too late. A lost tick or external edge shows up as a pending bit that never rises. The behavioural model in the bench predicts every output bit on every cycle, so any such divergence is flagged at the first cycle where it becomes visible.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      OP_PEND_SET = 2'd0,
      OP_PEND_CLR = 2'd1,
      OP_EN_SET   = 2'd2,
      OP_EN_CLR   = 2'd3
   } req_op_e;

   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_DONE = 3'd1,
      EV_ACK  = 3'd2,
      EV_REQ  = 3'd3,
      EV_TICK = 3'd4,
      EV_EDGE = 3'd5
   } event_e;

   // fixed exception numbers; the sync-fault window and the ext base are behavioural
   localparam int XN_NMI       = 2;
   localparam int XN_HARD      = 3;
   localparam int XN_SVC       = 11;
   localparam int XN_DEBUG     = 12;
   localparam int XN_PSV       = 14;
   localparam int XN_TICK      = 15;
   localparam int XN_FIRST_EXT = 16;

   localparam logic [15:0] SYS_ENA_RST =
      (16'd1 << XN_NMI) | (16'd1 << XN_HARD) | (16'd1 << XN_SVC) |
      (16'd1 << XN_DEBUG) | (16'd1 << XN_PSV) | (16'd1 << XN_TICK);

endpackage

// File: rtl/exc_edge_track.sv
module exc_edge_track #(
   parameter int LINES = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LINES-1:0] lvl_i,
   input  logic             adv_i,
   output logic [LINES-1:0] rise_o
);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic prev_q;
      // history only moves on cycles where edges may be consumed
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    prev_q <= 1'b0;
         else if (adv_i) prev_q <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~prev_q;
   end

endmodule

// File: rtl/exc_event_arb.sv
module exc_event_arb
   import exc_seq_pkg::*;
(
   input  logic   done_i,
   input  logic   ack_ok_i,
   input  logic   req_i,
   input  logic   tick_i,
   input  logic   edge_i,
   output event_e ev_o
);

   always_comb begin
      if (done_i)        ev_o = EV_DONE;
      else if (ack_ok_i) ev_o = EV_ACK;
      else if (req_i)    ev_o = EV_REQ;
      else if (tick_i)   ev_o = EV_TICK;
      else if (edge_i)   ev_o = EV_EDGE;
      else               ev_o = EV_NONE;
   end

endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
   import exc_seq_pkg::*;
#(
   parameter int VW  = 5,
   parameter int SPW = 10
) (
   input  logic [VW-1:0]         vec_i,
   input  logic                  en_i,
   input  logic signed [SPW-1:0] prio_i,
   input  logic signed [SPW-1:0] exec_i,
   output logic                  esc_o,
   output logic                  lock_o
);

   logic                  sync_fault;
   logic signed [SPW-1:0] eff_prio;

   assign sync_fault = (vec_i >= VW'(XN_HARD)) && (vec_i < VW'(XN_PSV));
   assign eff_prio   = (vec_i == VW'(XN_HARD)) ? -SPW'(1) : prio_i;
   assign esc_o      = sync_fault && ((eff_prio >= exec_i) || !en_i);
   // hard fault runs at -1, so it cannot preempt an execution priority of -1 or below
   assign lock_o     = esc_o && (exec_i < SPW'(0));

endmodule

// File: rtl/exc_state_sequencer.sv
module exc_state_sequencer
   import exc_seq_pkg::*;
#(
   parameter int NUM_EXT    = 8,
   parameter int PRIO_BITS  = 8,
   parameter bit LATCH_TICK = 1'b1,
   localparam int NUM_VEC   = XN_FIRST_EXT + NUM_EXT,
   localparam int VW        = $clog2(NUM_VEC),
   localparam int SPW       = PRIO_BITS + 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_EXT-1:0]    ext_lvl_i,
   input  logic                  req_valid_i,
   input  logic [1:0]            req_op_i,
   input  logic [VW-1:0]         req_vec_i,
   input  logic signed [SPW-1:0] req_prio_i,
   input  logic                  tick_i,
   input  logic signed [SPW-1:0] exec_prio_i,
   input  logic                  ack_i,
   input  logic [VW-1:0]         ack_vec_i,
   input  logic                  done_i,
   input  logic [VW-1:0]         done_vec_i,
   output logic [NUM_VEC-1:0]    pend_o,
   output logic [NUM_VEC-1:0]    act_o,
   output logic [NUM_VEC-1:0]    ena_o,
   output logic [VW-1:0]         cur_exc_o,
   output logic                  forced_o,
   output logic                  lockup_o,
   output logic                  cmp_bad_o,
   output logic                  ret_base_o
);

   if (NUM_EXT < 1 || NUM_VEC > 256) begin : g_bad_ext
      $error("exc_state_sequencer: NUM_EXT out of range");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("exc_state_sequencer: PRIO_BITS out of range");
   end

   localparam logic [NUM_VEC-1:0] ONE     = NUM_VEC'(1);
   localparam logic [NUM_VEC-1:0] ENA_RST = NUM_VEC'(SYS_ENA_RST);

   logic [NUM_VEC-1:0] pend_q, act_q, ena_q;
   logic [VW-1:0]      cur_q;
   logic               forced_q, lock_q, bad_q, base_q;

   function automatic logic vec_ok(input logic [VW-1:0] v);
      return (v != '0) && (int'(v) < NUM_VEC);
   endfunction

   logic [NUM_VEC-1:0] req_hot, ack_hot, done_hot;
   assign req_hot  = vec_ok(req_vec_i)  ? (ONE << req_vec_i)  : '0;
   assign ack_hot  = vec_ok(ack_vec_i)  ? (ONE << ack_vec_i)  : '0;
   assign done_hot = vec_ok(done_vec_i) ? (ONE << done_vec_i) : '0;

   logic ack_ok, done_legal;
   assign ack_ok     = ack_i && |(ack_hot & pend_q & ena_q);
   assign done_legal = |(done_hot & act_q);

   logic [NUM_VEC-1:0] lvl_full, rise_full;
   logic [NUM_EXT-1:0] rise;
   assign lvl_full  = {ext_lvl_i, {XN_FIRST_EXT{1'b0}}};
   assign rise_full = {rise, {XN_FIRST_EXT{1'b0}}};

   event_e ev;
   logic   tick_req;
   logic   esc, lock;

   if (LATCH_TICK) begin : g_tick_hold
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) tick_q <= 1'b0;
         else         tick_q <= tick_req && (ev != EV_TICK);
      end
      assign tick_req = tick_i | tick_q;
   end else begin : g_tick_direct
      assign tick_req = tick_i;
   end

   exc_edge_track #(.LINES(NUM_EXT)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (ext_lvl_i),
      .adv_i  ((ev == EV_NONE) || (ev == EV_EDGE)),
      .rise_o (rise)
   );

   exc_event_arb u_arb (
      .done_i   (done_i),
      .ack_ok_i (ack_ok),
      .req_i    (req_valid_i),
      .tick_i   (tick_req),
      .edge_i   (|rise),
      .ev_o     (ev)
   );

   exc_escalate #(.VW(VW), .SPW(SPW)) u_esc (
      .vec_i  (req_vec_i),
      .en_i   (|(req_hot & ena_q)),
      .prio_i (req_prio_i),
      .exec_i (exec_prio_i),
      .esc_o  (esc),
      .lock_o (lock)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q   <= '0;
         act_q    <= '0;
         ena_q    <= ENA_RST;
         cur_q    <= '0;
         forced_q <= 1'b0;
         lock_q   <= 1'b0;
         bad_q    <= 1'b0;
         base_q   <= 1'b0;
      end else begin
         bad_q <= 1'b0;
         case (ev)
            EV_DONE: begin
               if (!done_legal) begin
                  bad_q <= 1'b1;
               end else begin
                  act_q  <= act_q & ~done_hot;
                  base_q <= ($countones(act_q & ~done_hot) <= 1);
                  pend_q <= pend_q | (done_hot & lvl_full);
               end
            end
            EV_ACK: begin
               pend_q <= pend_q & ~ack_hot;
               act_q  <= act_q | ack_hot;
               cur_q  <= ack_vec_i;
            end
            EV_REQ: begin
               case (req_op_i)
                  OP_PEND_SET: begin
                     if (esc) begin
                        if (lock) begin
                           lock_q <= 1'b1;
                        end else begin
                           pend_q[XN_HARD] <= 1'b1;
                           forced_q        <= 1'b1;
                        end
                     end else begin
                        pend_q <= pend_q | req_hot;
                     end
                  end
                  OP_PEND_CLR: pend_q <= pend_q & ~req_hot;
                  OP_EN_SET:   ena_q  <= ena_q | req_hot;
                  default:     ena_q  <= ena_q & ~req_hot;
               endcase
            end
            EV_TICK: pend_q[XN_TICK] <= 1'b1;
            EV_EDGE: pend_q <= pend_q | rise_full;
            default: ;
         endcase
      end
   end

   assign pend_o     = pend_q;
   assign act_o      = act_q;
   assign ena_o      = ena_q;
   assign cur_exc_o  = cur_q;
   assign forced_o   = forced_q;
   assign lockup_o   = lock_q;
   assign cmp_bad_o  = bad_q;
   assign ret_base_o = base_q;

endmodule

// File: rtl/exc_state_sequencer_chk.sv
module exc_state_sequencer_chk #(
   parameter int NUM_VEC = 24,
   localparam int VW     = $clog2(NUM_VEC)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_valid_i,
   input logic               tick_i,
   input logic               ack_i,
   input logic [VW-1:0]      ack_vec_i,
   input logic               done_i,
   input logic [VW-1:0]      done_vec_i,
   input logic [NUM_VEC-1:0] pend_o,
   input logic [NUM_VEC-1:0] act_o,
   input logic [NUM_VEC-1:0] ena_o,
   input logic [VW-1:0]      cur_exc_o,
   input logic               forced_o,
   input logic               lockup_o,
   input logic               cmp_bad_o
);

   logic ack_in_range, done_in_range;
   assign ack_in_range  = (ack_vec_i != '0) && (int'(ack_vec_i) < NUM_VEC);
   assign done_in_range = (done_vec_i != '0) && (int'(done_vec_i) < NUM_VEC);

   assert_lockup_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lockup_o |=> lockup_o);

   assert_forced_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      forced_o |=> forced_o);

   assert_ack_takes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !done_i && ack_in_range && pend_o[ack_vec_i] && ena_o[ack_vec_i])
      |=> (act_o[$past(ack_vec_i)] && !pend_o[$past(ack_vec_i)]
           && cur_exc_o == $past(ack_vec_i)));

   assert_cur_only_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_i |=> $stable(cur_exc_o));

   assert_bad_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && done_in_range && !act_o[done_vec_i]) |=> cmp_bad_o);

   assert_bad_keeps_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && done_in_range && !act_o[done_vec_i]) |=> $stable(act_o));

   assert_done_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && done_in_range && act_o[done_vec_i]) |=> !act_o[$past(done_vec_i)]);

   assert_tick_pends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !done_i && !ack_i && !req_valid_i) |=> pend_o[15]);

endmodule

bind exc_state_sequencer exc_state_sequencer_chk #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/exc_state_sequencer_tb.sv
module exc_state_sequencer_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NUM_EXT = 8;
   localparam int PRIO_BITS = 8;
   localparam int NV  = 16 + NUM_EXT;
   localparam int VW  = $clog2(NV);
   localparam int SPW = PRIO_BITS + 2;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NUM_EXT-1:0]    lvl = '0;
   logic                  req_valid = 1'b0;
   logic [1:0]            req_op = '0;
   logic [VW-1:0]         req_vec = '0;
   logic signed [SPW-1:0] req_prio = '0;
   logic                  tick = 1'b0;
   logic signed [SPW-1:0] exec_prio = SPW'(256);
   logic                  ack = 1'b0;
   logic [VW-1:0]         ack_vec = '0;
   logic                  done = 1'b0;
   logic [VW-1:0]         done_vec = '0;

   logic [NV-1:0] pend, act, ena;
   logic [VW-1:0] cur;
   logic          forced, lockup, cmp_bad, ret_base;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   exc_state_sequencer #(.NUM_EXT(NUM_EXT), .PRIO_BITS(PRIO_BITS)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ext_lvl_i(lvl),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_vec_i(req_vec),
      .req_prio_i(req_prio), .tick_i(tick), .exec_prio_i(exec_prio),
      .ack_i(ack), .ack_vec_i(ack_vec), .done_i(done), .done_vec_i(done_vec),
      .pend_o(pend), .act_o(act), .ena_o(ena), .cur_exc_o(cur),
      .forced_o(forced), .lockup_o(lockup), .cmp_bad_o(cmp_bad), .ret_base_o(ret_base)
   );

   // ---------------- behavioural reference model ----------------
   logic [NV-1:0]      m_pend, m_act, m_ena;
   int                 m_cur;
   logic               m_forced, m_lock, m_bad, m_base, m_tick;
   logic [NUM_EXT-1:0] m_prev;

   always @(posedge clk) begin
      int  v, cnt, p, e;
      bit  treq, served;
      if (!rst_n) begin
         m_pend = '0; m_act = '0; m_cur = 0;
         m_ena = '0;
         m_ena[2] = 1; m_ena[3] = 1; m_ena[11] = 1; m_ena[12] = 1; m_ena[14] = 1; m_ena[15] = 1;
         m_forced = 0; m_lock = 0; m_bad = 0; m_base = 0; m_tick = 0; m_prev = '0;
      end else begin
         treq = m_tick || tick;
         served = 0;
         m_bad = 0;
         if (done) begin
            v = int'(done_vec);
            if (v == 0 || v >= NV || !m_act[v]) m_bad = 1;
            else begin
               m_act[v] = 0;
               cnt = 0;
               for (int k = 0; k < NV; k++) cnt += int'(m_act[k]);
               m_base = (cnt <= 1);
               if (v >= 16 && lvl[v-16]) m_pend[v] = 1;
            end
         end else if (ack && ack_vec != 0 && int'(ack_vec) < NV
                      && m_pend[ack_vec] && m_ena[ack_vec]) begin
            v = int'(ack_vec);
            m_pend[v] = 0; m_act[v] = 1; m_cur = v;
         end else if (req_valid) begin
            v = int'(req_vec);
            if (v != 0 && v < NV) begin
               case (req_op)
                  2'd0: begin
                     if (v >= 3 && v < 14) begin
                        p = (v == 3) ? -1 : int'(req_prio);
                        e = int'(exec_prio);
                        if (p >= e || !m_ena[v]) begin
                           if (e < 0) m_lock = 1;
                           else begin m_pend[3] = 1; m_forced = 1; end
                        end else m_pend[v] = 1;
                     end else m_pend[v] = 1;
                  end
                  2'd1: m_pend[v] = 0;
                  2'd2: m_ena[v] = 1;
                  default: m_ena[v] = 0;
               endcase
            end
         end else if (treq) begin
            m_pend[15] = 1; served = 1;
         end else begin
            for (int i = 0; i < NUM_EXT; i++)
               if (lvl[i] && !m_prev[i]) m_pend[16+i] = 1;
            m_prev = lvl;
         end
         m_tick = treq && !served;
      end
   end

   // every-cycle comparison, away from the active edge (R11 covers ordering)
   always @(negedge clk) begin
      if (rst_n) begin
         n_chk++;
         if (pend !== m_pend || act !== m_act || ena !== m_ena || int'(cur) != m_cur ||
             forced !== m_forced || lockup !== m_lock || cmp_bad !== m_bad ||
             ret_base !== m_base) begin
            n_bad++;
            $display("FAIL R11 model t=%0t actual pend=%h act=%h ena=%h cur=%0d f=%b l=%b b=%b r=%b expected pend=%h act=%h ena=%h cur=%0d f=%b l=%b b=%b r=%b",
                     $time, pend, act, ena, cur, forced, lockup, cmp_bad, ret_base,
                     m_pend, m_act, m_ena, m_cur, m_forced, m_lock, m_bad, m_base);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input int actual, input int expected);
      n_chk++;
      if (actual != expected) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic req(input logic [1:0] op, input int v, input int p);
      req_valid = 1'b1; req_op = op; req_vec = VW'(v); req_prio = SPW'(p);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_ack(input int v);
      ack = 1'b1; ack_vec = VW'(v);
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic do_done(input int v);
      done = 1'b1; done_vec = VW'(v);
      @(negedge clk);
      done = 1'b0;
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [NV-1:0] saved;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 enable mask", int'(ena), 32'h00D80C);
      chk("R1 pending", int'(pend), 0);
      chk("R1 active", int'(act), 0);
      chk("R1 flags", int'({forced, lockup, cmp_bad, ret_base}), 0);

      // R2 edge latching
      lvl[0] = 1'b1; idle(2);
      chk("R2 rise pends 16", int'(pend[16]), 1);
      lvl[0] = 1'b0; idle(2);
      chk("R2 fall keeps pend", int'(pend[16]), 1);

      // R6 acknowledge
      req(2'd2, 16, 0); req(2'd2, 17, 0); req(2'd2, 18, 0);
      do_ack(16);
      chk("R6 ack active", int'(act[16]), 1);
      chk("R6 ack clears pend", int'(pend[16]), 0);
      chk("R6 ack current", int'(cur), 16);
      do_ack(17);
      chk("R6 unqualified ack ignored", int'(act[17]), 0);
      chk("R6 current unchanged", int'(cur), 16);

      // R3 re-pend on completion while line high
      lvl[0] = 1'b1; idle(2);
      req(2'd1, 16, 0);
      chk("R10 clear pend", int'(pend[16]), 0);
      do_done(16);
      chk("R3 repend high line", int'(pend[16]), 1);
      chk("R5 done clears active", int'(act[16]), 0);
      chk("R5 base none left", int'(ret_base), 1);
      do_ack(16);
      lvl[0] = 1'b0; idle(1);
      do_done(16);
      chk("R3 low line no repend", int'(pend[16]), 0);

      // R4 illegal completion
      do_done(20);
      chk("R4 bad completion flag", int'(cmp_bad), 1);
      idle(1);
      chk("R4 flag one cycle", int'(cmp_bad), 0);

      // R5 return-to-base counting
      req(2'd0, 16, 0); req(2'd0, 17, 0); req(2'd0, 18, 0);
      do_ack(16); do_ack(17); do_ack(18);
      do_done(18);
      chk("R5 two remain", int'(ret_base), 0);
      chk("R5 cleared 18", int'(act[18]), 0);
      do_done(17);
      chk("R5 one remains", int'(ret_base), 1);
      do_done(16);

      // R7 escalation
      exec_prio = SPW'(100);
      req(2'd0, 5, 50);
      chk("R7 disabled escalates", int'(pend[3]), 1);
      chk("R7 original not pended", int'(pend[5]), 0);
      chk("R7 forced set", int'(forced), 1);
      req(2'd1, 3, 0);
      req(2'd2, 5, 0);
      req(2'd0, 5, 50);
      chk("R7 takeable pends own", int'(pend[5]), 1);
      chk("R7 no hard fault", int'(pend[3]), 0);
      req(2'd1, 5, 0);
      req(2'd0, 5, 200);
      chk("R7 low priority escalates", int'(pend[3]), 1);
      chk("R7 low priority not own", int'(pend[5]), 0);
      req(2'd1, 3, 0);

      // R9 / R11 tick deferred behind a request
      req(2'd2, 19, 0);
      req_valid = 1'b1; req_op = 2'd0; req_vec = VW'(19); tick = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; tick = 1'b0;
      chk("R11 request first", int'(pend[19]), 1);
      chk("R11 tick deferred", int'(pend[15]), 0);
      idle(1);
      chk("R9 tick served later", int'(pend[15]), 1);
      // R11 completion beats acknowledge
      ack = 1'b1; ack_vec = VW'(19); done = 1'b1; done_vec = VW'(20);
      @(negedge clk);
      ack = 1'b0; done = 1'b0;
      chk("R11 completion wins", int'(cmp_bad), 1);
      chk("R11 ack dropped", int'(act[19]), 0);
      do_ack(19);
      do_done(19);

      // R10 invalid vectors and disable
      saved = pend;
      req(2'd0, 0, 0);
      req(2'd0, 30, 0);
      chk("R10 invalid vectors ignored", int'(pend), int'(saved));
      req(2'd3, 11, 0);
      chk("R10 disable", int'(ena[11]), 0);

      // R8 lockup
      exec_prio = -SPW'(1);
      req(2'd0, 4, 0);
      chk("R8 lockup set", int'(lockup), 1);
      chk("R8 nothing pended", int'(pend[3]) + int'(pend[4]), 0);
      idle(3);
      chk("R8 lockup sticky", int'(lockup), 1);

      // mixed traffic, checked by the model each cycle
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         lvl = NUM_EXT'($urandom);
         exec_prio = (r == 0) ? -SPW'(1) : SPW'($urandom_range(0, 256));
         req_valid = ($urandom_range(0, 2) == 0);
         req_op = 2'($urandom);
         req_vec = VW'($urandom_range(0, 31));
         req_prio = SPW'($urandom_range(0, 255));
         tick = ($urandom_range(0, 4) == 0);
         ack = ($urandom_range(0, 2) == 0);
         ack_vec = VW'($urandom_range(1, NV - 1));
         done = ($urandom_range(0, 3) == 0);
         done_vec = VW'($urandom_range(1, NV - 1));
         @(negedge clk);
      end
      req_valid = 1'b0; tick = 1'b0; ack = 1'b0; done = 1'b0;
      idle(4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule